// File: doc/BRIEF.md
# HDLC Receive Address Filter

This block sits between a receive framer and the receive FIFO. It inspects the first two bytes of every incoming frame and decides whether the frame belongs to this station. The framer has already removed flags and stuffed zeros. Frames that pass are forwarded byte for byte to the FIFO write port. Frames that fail produce no FIFO write at all.

The first byte is parked in a one-byte holding register until the second byte has arrived and the verdict is known. That register then serves as a one-stage delay line for the rest of the frame. As a result, byte order is preserved and accepted frames carry the same latency whether filtering is on or off.

The first-byte comparison can cover six or seven bits. Each of the two byte comparisons has its own enable. A received seven-bit value of all ones acts as an all-call address that overrides the configured masks.

Top module: `hdlc_rx_addr_filter`

## Requirements
- R1: With `cfg_wide1` low, the first byte matches when `in_data[7:2]` of that byte equals `cfg_addr1[6:1]`. Bit 7 is paired with `cfg_addr1[6]`. Bits 1 and 0 of the byte and `cfg_addr1[0]` are not compared.
- R2: With `cfg_wide1` high, the first byte matches when its bits 7..1 equal `cfg_addr1[6:0]`.
- R3: The second byte matches when its bits 7..1 equal `cfg_addr2[6:0]`. Its bit 0 is never compared.
- R4: When `cfg_a1_en` is low, the first byte counts as matching. When `cfg_a2_en` is low, the second byte counts as matching.
- R5: A first byte whose bits 7..1 are 1111111, with `cfg_a1_en` high, accepts the frame regardless of both masks. The same holds for a second byte whose bits 7..1 are 1111111, with `cfg_a2_en` high.
- R6: With `cfg_rec_en` high, a frame is accepted only if both byte checks match or an all-call (R5) is seen. Otherwise no byte of the frame is written.
- R7: With `cfg_rec_en` low, every frame is written whole, including frames of a single byte.
- R8: An accepted frame has every byte written exactly once and in arrival order. Byte i is written on the clock edge that takes in byte i+1, and the final byte is written on the edge after the one that takes it in.
- R9: `fifo_last` is high together with `fifo_wr` on the final byte of a written frame, and low at all other times.
- R10: With `cfg_rec_en` high, a frame that ends with its first byte (fewer than two address bytes) is discarded.
- R11: The verdict is taken once per frame, at the second byte, and holds to the end of the frame regardless of later byte values. A new start-of-frame starts a fresh decision.
- R12: While reset is asserted, and after it is released until a frame is accepted, `fifo_wr` and `fifo_last` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_sof | input | 1 | Marks the first byte of a frame (qualified by `in_vld`) |
| in_vld | input | 1 | Received byte strobe |
| in_eof | input | 1 | Marks the final byte of a frame (qualified by `in_vld`) |
| in_data | input | 8 | Received byte |
| cfg_rec_en | input | 1 | Address filtering enable |
| cfg_addr1 | input | 7 | First-byte address; bits 6..1 used in six-bit mode |
| cfg_a1_en | input | 1 | First-byte comparison enable |
| cfg_wide1 | input | 1 | Selects the seven-bit first-byte comparison |
| cfg_addr2 | input | 7 | Second-byte address |
| cfg_a2_en | input | 1 | Second-byte comparison enable |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_data | output | 8 | Byte to write |
| fifo_last | output | 1 | Final byte of the frame |

## Verification
The assertions rely on three properties of the input stream. Start-of-frame arrives only when the previous frame has fully drained, which needs at least one idle cycle after an end-of-frame. Every frame carries exactly one `in_sof` and one `in_eof`. Configuration is held steady for the whole of a frame. The bench drives each frame with one byte per cycle, then leaves three idle cycles, and changes configuration only between frames. The stimulus sweeps all sixteen combinations of the four mode bits, all 128 upper-seven-bit values of the first byte, and matching, all-call and mismatching second bytes. It also covers one-, two- and four-byte frames.

// File: rtl/hdlc_af_pkg.sv
package hdlc_af_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ADDR  = 3'd1,
    ST_PASS  = 3'd2,
    ST_DROP  = 3'd3,
    ST_FLUSH = 3'd4
  } af_state_t;

endpackage

// File: rtl/hdlc_af_cmp.sv
module hdlc_af_cmp #(
  parameter int unsigned DW = 8
) (
  input  logic [DW-2:0] first_hi,
  input  logic [DW-2:0] second_hi,
  input  logic [DW-2:0] cfg_addr1,
  input  logic          cfg_a1_en,
  input  logic          cfg_wide1,
  input  logic [DW-2:0] cfg_addr2,
  input  logic          cfg_a2_en,
  output logic          hit_all,
  output logic          accept
);

  localparam int unsigned AW = DW - 1;

  logic [AW-1:0] eq1;
  logic [AW-1:0] eq2;
  logic          cmp1;
  logic          m1;
  logic          m2;
  logic          all1;
  logic          all2;

  // per-bit equality, received bit k+1 against configured bit k
  for (genvar i = 0; i < AW; i++) begin : g_bit
    assign eq1[i] = ~(first_hi[i]  ^ cfg_addr1[i]);
    assign eq2[i] = ~(second_hi[i] ^ cfg_addr2[i]);
  end

  always_comb begin
    cmp1    = cfg_wide1 ? (&eq1) : (&eq1[AW-1:1]);
    m1      = ~cfg_a1_en | cmp1;
    m2      = ~cfg_a2_en | (&eq2);
    all1    = cfg_a1_en & (&first_hi);
    all2    = cfg_a2_en & (&second_hi);
    hit_all = all1 | all2;
    accept  = hit_all | (m1 & m2);
  end

endmodule

// File: rtl/hdlc_af_seq.sv
module hdlc_af_seq
  import hdlc_af_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_sof,
  input  logic          in_vld,
  input  logic          in_eof,
  input  logic [DW-1:0] in_data,
  input  logic          cfg_rec_en,
  input  logic          dec_accept,
  input  logic          dec_all,
  output logic [DW-2:0] hold_hi,
  output logic          fifo_wr,
  output logic [DW-1:0] fifo_data,
  output logic          fifo_last
);

  af_state_t     st_q, st_d;
  logic [DW-1:0] hold_q;
  logic          hold_ld;
  logic          wr_d, wr_q;
  logic          last_d, last_q;
  logic [DW-1:0] data_q;

  // next-state and enables
  always_comb begin
    st_d    = st_q;
    hold_ld = 1'b0;
    wr_d    = 1'b0;
    last_d  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (in_vld && in_sof) begin
          hold_ld = 1'b1;
          if (in_eof) st_d = cfg_rec_en ? ST_IDLE : ST_FLUSH;
          else        st_d = cfg_rec_en ? ST_ADDR : ST_PASS;
        end
      end
      ST_ADDR: begin
        if (in_vld) begin
          if (dec_accept) begin
            wr_d    = 1'b1;
            hold_ld = 1'b1;
            st_d    = in_eof ? ST_FLUSH : ST_PASS;
          end else begin
            st_d    = in_eof ? ST_IDLE : ST_DROP;
          end
        end
      end
      ST_PASS: begin
        if (in_vld) begin
          wr_d    = 1'b1;
          hold_ld = 1'b1;
          if (in_eof) st_d = ST_FLUSH;
        end
      end
      ST_DROP: begin
        if (in_vld && in_eof) st_d = ST_IDLE;
      end
      ST_FLUSH: begin
        wr_d   = 1'b1;
        last_d = 1'b1;
        st_d   = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      hold_q <= '0;
      wr_q   <= 1'b0;
      last_q <= 1'b0;
      data_q <= '0;
    end else begin
      st_q   <= st_d;
      wr_q   <= wr_d;
      last_q <= last_d;
      if (hold_ld) hold_q <= in_data;
      if (wr_d)    data_q <= hold_q;
    end
  end

  assign hold_hi   = hold_q[DW-1:1];
  assign fifo_wr   = wr_q;
  assign fifo_data = data_q;
  assign fifo_last = last_q;

  assert_drop_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DROP) |=> !fifo_wr);

  assert_allcall_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ADDR && in_vld && dec_all) |=> fifo_wr);

  assert_short_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && cfg_rec_en && in_vld && in_sof && in_eof)
      |=> (!fifo_wr && st_q == ST_IDLE));

  assert_bypass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && !cfg_rec_en && in_vld && in_sof)
      |=> (st_q == ST_PASS || st_q == ST_FLUSH));

  assert_stream_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PASS && in_vld) |=> fifo_wr);

  assert_last_marks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_last |-> fifo_wr);

endmodule

// File: rtl/hdlc_rx_addr_filter.sv
module hdlc_rx_addr_filter #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_sof,
  input  logic          in_vld,
  input  logic          in_eof,
  input  logic [DW-1:0] in_data,
  input  logic          cfg_rec_en,
  input  logic [DW-2:0] cfg_addr1,
  input  logic          cfg_a1_en,
  input  logic          cfg_wide1,
  input  logic [DW-2:0] cfg_addr2,
  input  logic          cfg_a2_en,
  output logic          fifo_wr,
  output logic [DW-1:0] fifo_data,
  output logic          fifo_last
);

  logic [1:0]    rst_sync_q;
  logic          rst_n_int;
  logic [DW-2:0] hold_hi;
  logic          dec_accept;
  logic          dec_all;

  // assert asynchronously, release on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  hdlc_af_cmp #(.DW(DW)) i_cmp (
    .first_hi  (hold_hi),
    .second_hi (in_data[DW-1:1]),
    .cfg_addr1 (cfg_addr1),
    .cfg_a1_en (cfg_a1_en),
    .cfg_wide1 (cfg_wide1),
    .cfg_addr2 (cfg_addr2),
    .cfg_a2_en (cfg_a2_en),
    .hit_all   (dec_all),
    .accept    (dec_accept)
  );

  hdlc_af_seq #(.DW(DW)) i_seq (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .in_sof     (in_sof),
    .in_vld     (in_vld),
    .in_eof     (in_eof),
    .in_data    (in_data),
    .cfg_rec_en (cfg_rec_en),
    .dec_accept (dec_accept),
    .dec_all    (dec_all),
    .hold_hi    (hold_hi),
    .fifo_wr    (fifo_wr),
    .fifo_data  (fifo_data),
    .fifo_last  (fifo_last)
  );

endmodule

// File: tb/test_hdlc_rx_addr_filter.sv
`timescale 1ns/1ps
module test_hdlc_rx_addr_filter;

  localparam logic [6:0] A1 = 7'b1010011;
  localparam logic [6:0] A2 = 7'b0110101;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_sof, in_vld, in_eof;
  logic [7:0] in_data;
  logic       cfg_rec_en, cfg_a1_en, cfg_wide1, cfg_a2_en;
  logic [6:0] cfg_addr1, cfg_addr2;
  logic       fifo_wr, fifo_last;
  logic [7:0] fifo_data;

  int errors = 0;
  int checks = 0;
  logic [7:0] cap_d [0:15];
  logic       cap_l [0:15];
  int         cap_n = 0;
  logic       rst_seen_wr = 1'b0;

  always #10 clk = ~clk;

  hdlc_rx_addr_filter i_hdlc_rx_addr_filter (
    .clk(clk), .rst_n(rst_n), .in_sof(in_sof), .in_vld(in_vld),
    .in_eof(in_eof), .in_data(in_data), .cfg_rec_en(cfg_rec_en),
    .cfg_addr1(cfg_addr1), .cfg_a1_en(cfg_a1_en), .cfg_wide1(cfg_wide1),
    .cfg_addr2(cfg_addr2), .cfg_a2_en(cfg_a2_en), .fifo_wr(fifo_wr),
    .fifo_data(fifo_data), .fifo_last(fifo_last)
  );

  always @(negedge clk) begin
    if (fifo_wr && cap_n < 16) begin
      cap_d[cap_n] = fifo_data;
      cap_l[cap_n] = fifo_last;
    end
    if (fifo_wr) cap_n = cap_n + 1;
    if (fifo_last && !fifo_wr) rst_seen_wr = 1'b1;
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R8 watchdog: actual=timeout expected=completion");
    summary();
  end

  function automatic bit exp_accept(input logic [7:0] b1, input logic [7:0] b2);
    int v1, v2;
    bit m1, m2, all;
    v1  = int'(b1) / 2;
    v2  = int'(b2) / 2;
    all = (cfg_a1_en && v1 == 127) || (cfg_a2_en && v2 == 127);
    if (cfg_wide1) m1 = (v1 == int'(cfg_addr1));
    else           m1 = (int'(b1) / 4 == int'(cfg_addr1) / 2);
    m1 = m1 || !cfg_a1_en;
    m2 = (v2 == int'(cfg_addr2)) || !cfg_a2_en;
    return all || (m1 && m2);
  endfunction

  task automatic frame(input int len, input logic [7:0] b0, input logic [7:0] b1,
                       input logic [7:0] b2, input logic [7:0] b3, input string tag);
    logic [7:0] bb [0:3];
    bit acc, bad;
    int n_exp;
    bb[0] = b0; bb[1] = b1; bb[2] = b2; bb[3] = b3;
    cap_n = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_vld = 1'b1; in_data = bb[i];
      in_sof = (i == 0); in_eof = (i == len - 1);
    end
    @(negedge clk);
    in_vld = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_data = 8'h00;
    repeat (3) @(negedge clk);
    if (!cfg_rec_en)   acc = 1'b1;
    else if (len < 2)  acc = 1'b0;
    else               acc = exp_accept(b0, b1);
    n_exp = acc ? len : 0;
    bad = (cap_n != n_exp);
    if (!bad)
      for (int i = 0; i < n_exp; i++)
        if (cap_d[i] !== bb[i] || cap_l[i] !== (i == n_exp - 1)) bad = 1'b1;
    checks++;
    if (bad) begin
      errors++;
      $display("FAIL %s: len=%0d b=%h %h cfg=%b%b%b%b actual writes=%0d first=%h expected writes=%0d first=%h",
               tag, len, b0, b1, cfg_rec_en, cfg_a1_en, cfg_a2_en, cfg_wide1,
               cap_n, (cap_n > 0) ? cap_d[0] : 8'h00, n_exp, b0);
    end
  endtask

  initial begin
    string tag;
    logic [7:0] b1, b2;
    rst_n = 1'b0;
    in_sof = 1'b0; in_vld = 1'b0; in_eof = 1'b0; in_data = 8'h00;
    cfg_rec_en = 1'b1; cfg_a1_en = 1'b1; cfg_a2_en = 1'b1; cfg_wide1 = 1'b0;
    cfg_addr1 = A1; cfg_addr2 = A2;
    repeat (3) @(negedge clk);
    checks++;
    if (fifo_wr !== 1'b0 || fifo_last !== 1'b0) begin
      errors++;
      $display("FAIL R12 reset: actual wr=%b last=%b expected wr=0 last=0", fifo_wr, fifo_last);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    checks++;
    if (cap_n != 0 || fifo_wr !== 1'b0) begin
      errors++;
      $display("FAIL R12 after reset: actual writes=%0d expected writes=0", cap_n);
    end

    for (int c = 0; c < 16; c++) begin
      cfg_rec_en = c[3]; cfg_a1_en = c[2]; cfg_a2_en = c[1]; cfg_wide1 = c[0];
      for (int v = 0; v < 128; v++) begin
        for (int k = 0; k < 3; k++) begin
          b1 = {7'(v), v[0]};
          if (k == 0)      b2 = {A2, 1'b0};
          else if (k == 1) b2 = 8'hFF;
          else             b2 = {A2 ^ 7'h11, 1'b1};
          if (!cfg_rec_en) tag = "R7";
          else if ((cfg_a1_en && v == 127) || (cfg_a2_en && k == 1)) tag = "R5";
          else if (!cfg_a1_en || !cfg_a2_en) tag = "R4";
          else if (cfg_wide1) tag = "R2";
          else tag = "R1";
          // third byte all ones must not alter the verdict
          frame(3, b1, b2, 8'hFF, 8'h00, {tag, " R3 R6 R8 R9 R11"});
        end
      end
      // short and long frames
      frame(1, {A1, 1'b0}, 8'h00, 8'h00, 8'h00, cfg_rec_en ? "R10" : "R7");
      frame(1, 8'hFF, 8'h00, 8'h00, 8'h00, cfg_rec_en ? "R10" : "R7");
      frame(2, {A1, 1'b1}, {A2, 1'b1}, 8'h00, 8'h00, "R8 R9");
      frame(4, 8'h00, 8'h3C, 8'hFE, 8'h81, "R6 R11");
      frame(4, {A1, 1'b0}, {A2, 1'b0}, 8'h00, 8'hFF, "R8 R11");
    end
    checks++;
    if (rst_seen_wr) begin
      errors++;
      $display("FAIL R9: actual last without write expected none");
    end
    summary();
  end

endmodule